// File: doc/BRIEF.md
# Weighted Periodic Pattern Compressor

This block folds a serial stream of per-store clean decisions into one repeating pattern of `K` bits. Each accepted stream bit is assigned to pattern slot `n mod K`, where `n` counts accepted bits from the start of the stream. Each slot keeps separate tallies of the ones and zeros it has received.

When the final bit of a stream arrives, every slot picks its output bit by comparing two weighted costs:

- The cost of a 0 is the number of ones times the miss weight, which prices a clean that should have happened and did not.
- The cost of a 1 is the number of zeros times the extra weight, which prices a clean that was not needed.

The slot outputs 1 only when the cost of a 1 does not exceed the cost of a 0. Because the extra weight is larger by default, a 1 needs a clear majority of ones.

The finished pattern is presented with a one-cycle done pulse, and the tallies are cleared in the same edge. A new stream may begin on the very next cycle. The block sits between an offline profiling feed and the controller that later replays the pattern.

Top module: `periodic_pattern_compressor`

## Requirements
- R1: After reset, `pattern` is all zeros and `done` is 0.
- R2: The n-th accepted bit of a stream (counting from 0) is tallied in slot `n mod K`, with K = 8 by default. Slot j drives `pattern[j]`.
- R3: Slot j outputs 1 exactly when it saw at least one 1 and `W_EXTRA*zeros <= W_MISS*ones`, with defaults W_MISS = 1 and W_EXTRA = 2.
- R4: Under the default weights, a slot that saw equally many ones and zeros outputs 0.
- R5: A slot that saw no ones outputs 0. This includes slots that a stream shorter than K never reached.
- R6: A bit accepted with `in_valid` and `in_last` both high is part of the stream. `done` is high for exactly the cycle after that edge, and the new `pattern` appears on the same edge.
- R7: `pattern` holds its value between done pulses. `in_bit` and `in_last` have no effect while `in_valid` is low.
- R8: After a last bit, all tallies and the slot index are cleared. The next stream may start in the following cycle, and its result does not depend on earlier streams.
- R9: The tally counters are sized so that a stream of up to `MAX_LEN` bits never wraps them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Stream bit is present this cycle |
| in_bit | input | 1 | Desired clean decision for this store instance |
| in_last | input | 1 | This bit ends the stream |
| pattern | output | K | Compressed pattern; bit j belongs to slot j |
| done | output | 1 | One-cycle pulse when a new pattern is presented |

## Verification
A tally that drifts, a misplaced slot index or a wrong cost comparison stays hidden until the last bit of a stream. It then shows as a wrong bit of `pattern` in the cycle right after that bit, and nothing about it is visible before then. For this reason, every stream ends with a full comparison of `pattern`. The cycles in between check that `done` stays low and that `pattern` is frozen. Streams are built so that every slot sees every small (ones, zeros) pair, which also exercises the tie and empty-slot cases.

// File: rtl/ppc_pkg.sv
package ppc_pkg;

   // Bits per tally counter: enough for ceil(max_len/k) plus margin.
   function automatic int unsigned tally_width(input int unsigned max_len,
                                               input int unsigned k);
      return $clog2(max_len / k + 2);
   endfunction

   // Width reserved for a weight operand.
   localparam int unsigned WEIGHT_W = 16;

endpackage

// File: rtl/ppc_slot_index.sv
module ppc_slot_index #(
   parameter int unsigned K     = 8,
   parameter int unsigned IDX_W = (K > 1) ? $clog2(K) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   input  logic             restart,
   output logic [IDX_W-1:0] slot
);

   logic [IDX_W-1:0] slot_q;
   logic [IDX_W-1:0] slot_inc;

   generate
      if ((K & (K - 1)) == 0) begin : g_pow2
         // Natural wrap of the counter is the modulo.
         assign slot_inc = slot_q + IDX_W'(1);
      end else begin : g_generic
         assign slot_inc = (slot_q == IDX_W'(K - 1)) ? '0 : slot_q + IDX_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_q <= '0;
      end else if (restart) begin
         slot_q <= '0;
      end else if (advance) begin
         slot_q <= slot_inc;
      end
   end

   assign slot = slot_q;

   // R8
   restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> slot_q == '0);

   // R2
   slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_q <= IDX_W'(K - 1));

endmodule

// File: rtl/ppc_lane.sv
module ppc_lane #(
   parameter int unsigned CNT_W   = 10,
   parameter int unsigned W_MISS  = 1,
   parameter int unsigned W_EXTRA = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic bit_in,
   input  logic flush,
   output logic choose_one
);

   import ppc_pkg::*;

   localparam int unsigned PW = CNT_W + WEIGHT_W;

   logic [CNT_W-1:0] ones_q, zeros_q;
   logic [CNT_W-1:0] ones_n, zeros_n;
   logic [PW-1:0]    cost_zero, cost_one;

   // Tallies including the bit presented this cycle.
   assign ones_n  = ones_q  + {{(CNT_W-1){1'b0}}, (hit &  bit_in)};
   assign zeros_n = zeros_q + {{(CNT_W-1){1'b0}}, (hit & ~bit_in)};

   // Cost of outputting 0: every wanted clean is missed.
   assign cost_zero = PW'(ones_n) * PW'(W_MISS);
   // Cost of outputting 1: every unwanted clean is paid for.
   assign cost_one  = PW'(zeros_n) * PW'(W_EXTRA);

   assign choose_one = (ones_n != '0) && (cost_one <= cost_zero);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ones_q  <= '0;
         zeros_q <= '0;
      end else if (flush) begin
         ones_q  <= '0;
         zeros_q <= '0;
      end else begin
         ones_q  <= ones_n;
         zeros_q <= zeros_n;
      end
   end

   // R9
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (bit_in ? (ones_q != '1) : (zeros_q != '1)));

   // R8
   flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (ones_q == '0 && zeros_q == '0));

   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit && !flush) |=> ($stable(ones_q) && $stable(zeros_q)));

endmodule

// File: rtl/periodic_pattern_compressor.sv
module periodic_pattern_compressor #(
   parameter int unsigned K       = 8,
   parameter int unsigned MAX_LEN = 4096,
   parameter int unsigned W_MISS  = 1,
   parameter int unsigned W_EXTRA = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic         in_bit,
   input  logic         in_last,
   output logic [K-1:0] pattern,
   output logic         done
);

   import ppc_pkg::*;

   localparam int unsigned IDX_W = (K > 1) ? $clog2(K) : 1;
   localparam int unsigned CNT_W = tally_width(MAX_LEN, K);

   generate
      if (K < 2) begin : g_bad_k
         $error("K must be at least 2");
      end
      if (MAX_LEN < K) begin : g_bad_len
         $error("MAX_LEN must be at least K");
      end
      if (W_MISS == 0 || W_EXTRA == 0) begin : g_bad_w0
         $error("weights must be nonzero");
      end
      if (W_MISS >= (1 << WEIGHT_W) || W_EXTRA >= (1 << WEIGHT_W)) begin : g_bad_w1
         $error("weights exceed WEIGHT_W bits");
      end
   endgenerate

   logic             finish;
   logic [IDX_W-1:0] slot;
   logic [K-1:0]     choice;
   logic [K-1:0]     pattern_q;
   logic             done_q;

   assign finish = in_valid & in_last;

   ppc_slot_index #(.K(K), .IDX_W(IDX_W)) u_index (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (in_valid),
      .restart (finish),
      .slot    (slot)
   );

   generate
      for (genvar g = 0; g < K; g++) begin : g_lane
         logic lane_hit;
         assign lane_hit = in_valid && (slot == IDX_W'(g));
         ppc_lane #(.CNT_W(CNT_W), .W_MISS(W_MISS), .W_EXTRA(W_EXTRA)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .hit        (lane_hit),
            .bit_in     (in_bit),
            .flush      (finish),
            .choose_one (choice[g])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pattern_q <= '0;
         done_q    <= 1'b0;
      end else begin
         done_q <= finish;
         if (finish) begin
            pattern_q <= choice;
         end
      end
   end

   assign pattern = pattern_q;
   assign done    = done_q;

   // R6
   done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_last) |=> done);

   // R6
   done_only_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && in_last) |=> !done);

   // R7
   pattern_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(pattern));

endmodule

// File: tb/tb_periodic_pattern_compressor.sv
module tb_periodic_pattern_compressor;

   localparam int K = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_bit = 1'b0;
   logic         in_last = 1'b0;
   logic [K-1:0] pattern;
   logic         done;

   int total = 0;
   int bad = 0;
   int ones_m [K];
   int zeros_m [K];
   int idx_m = 0;
   logic [K-1:0] held = '0;
   logic [15:0]  lfsr = 16'hACE1;

   always #2.5 clk = ~clk;

   periodic_pattern_compressor #(.K(K)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
      .in_last(in_last), .pattern(pattern), .done(done)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // R3 R4 R5: expected slot bit from its tallies, default weights.
   function automatic logic [K-1:0] expected_pattern();
      logic [K-1:0] r;
      for (int p = 0; p < K; p++)
         r[p] = (ones_m[p] > 0) && (2 * zeros_m[p] <= ones_m[p]);
      return r;
   endfunction

   function automatic logic next_rand();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      return lfsr[0];
   endfunction

   // Called at a negedge; returns at the following negedge.
   task automatic step(input logic v, input logic b, input logic l);
      logic [K-1:0] exp_pat;
      in_valid = v; in_bit = b; in_last = l;
      exp_pat = held;
      if (v) begin
         if (b) ones_m[idx_m]++; else zeros_m[idx_m]++;
         idx_m = (idx_m + 1) % K;
         if (l) begin
            exp_pat = expected_pattern();
            for (int p = 0; p < K; p++) begin ones_m[p] = 0; zeros_m[p] = 0; end
            idx_m = 0;
         end
      end
      @(posedge clk); #1;
      check(done == (v && l), "R6 done timing", int'(done), int'(v && l));
      if (v && l) check(pattern == exp_pat, "R2/R3 pattern", int'(pattern), int'(exp_pat));
      else        check(pattern == held, "R7 pattern hold", int'(pattern), int'(held));
      held = exp_pat;
      @(negedge clk);
   endtask

   // Idle cycle with junk on the data and last lines (R7).
   task automatic gap();
      step(1'b0, next_rand(), 1'b1);
   endtask

   initial begin
      #1000000;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      string ex;
      for (int p = 0; p < K; p++) begin ones_m[p] = 0; zeros_m[p] = 0; end
      repeat (3) @(posedge clk);
      #1;
      // R1
      check(pattern == '0, "R1 reset pattern", int'(pattern), 0);
      check(done == 1'b0, "R1 reset done", int'(done), 0);
      @(negedge clk); rst_n = 1'b1;
      gap(); gap();

      // R3 R4 R5 R8: every slot sees (o ones, z zeros), back-to-back streams.
      for (int o = 0; o <= 6; o++) begin
         for (int z = 0; z <= 6; z++) begin
            int len;
            len = K * (o + z);
            if (len == 0) continue;
            for (int n = 0; n < len; n++)
               step(1'b1, (n / K) < o, n == len - 1);
            check(pattern == (((o > 0) && (2 * z <= o)) ? {K{1'b1}} : '0),
                  "R3/R4 sweep", int'(pattern), (o > 0 && 2 * z <= o) ? 255 : 0);
         end
      end

      // R5: short streams of ones leave unreached slots at 0.
      for (int len = 1; len < K; len++) begin
         for (int n = 0; n < len; n++) step(1'b1, 1'b1, n == len - 1);
         check(pattern == K'((1 << len) - 1), "R5 short stream",
               int'(pattern), (1 << len) - 1);
      end

      // R2: pseudo-random streams with idle gaps.
      for (int len = 1; len <= 70; len++) begin
         for (int n = 0; n < len; n++) begin
            if (next_rand() && next_rand()) gap();
            step(1'b1, next_rand(), n == len - 1);
         end
      end

      // Mixed example stream.
      ex = "11011001100001010101000111";
      for (int n = 0; n < ex.len(); n++)
         step(1'b1, ex[n] == "1", n == ex.len() - 1);
      gap();

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule